// File: doc/BRIEF.md
# Strided Interleaved Memory Access Engine

This engine carries out one vector load or store against a word-interleaved, pipelined memory. A transfer is started with a base word address, a stride in words and a vector length. On each cycle the engine offers at most one element access. It steers that access to a bank chosen from the low address bits. A bank that was used less than four cycles earlier is not accessed again: the engine holds the element at the head of the sequence, raises a stall indication and waits for the bank to free. Elements are always issued in order.

Store data is fetched from a vector register read port that is indexed by the element number being issued. Load data arrives from the memory a fixed number of cycles after the access. The engine marks that data with its element number and a valid flag for a vector register write port, and pulses a completion flag when the transfer ends. Strides that keep returning to the same bank, such as any multiple of sixteen words, cut throughput to one element every four cycles even though the memory itself is pipelined.

Top module: `vmem_stride_engine`

## Requirements
- R1: Element i accesses word address base + i*stride, truncated to ADDR_W bits; stride is two's complement, so negative strides walk downward.
- R2: Each access selects bank mem_bank_o = word address modulo 16, which is the low 4 bits of mem_addr_o, with 16 banks.
- R3: No bank is accessed in a cycle less than 4 cycles after its previous access. Each element issues in the earliest cycle that respects this rule and is later than the previous element's issue, and stall_o is high in every cycle in which the element at the head is held.
- R4: A start is accepted only while busy_o is low. Element 0 can issue in the cycle after the start edge, and issue is strictly in element order, at most one element per cycle.
- R5: A requested length above 64 is treated as 64. A length of 0 makes no memory access and pulses done_o in the cycle after the start.
- R6: Load data sampled from mem_rdata_i is returned on wb_data_o with wb_valid_o exactly 12 cycles after its access, carrying the element index on wb_idx_o, in element order.
- R7: A store access drives mem_we_o high, and drives mem_wdata_o with rd_data_i while rd_idx_o carries the index of the element being issued.
- R8: done_o pulses for one cycle: for a load in the cycle after the last element is returned, and for a store in the cycle after the last access. busy_o is high from the cycle after the start until done_o, and low when done_o is high.
- R9: A start pulse while busy_o is high has no effect on the running transfer's addresses, count or timing.
- R10: After reset busy_o, stall_o, done_o, mem_req_o and wb_valid_o are low.
- R11: A stride that is a multiple of 16 words keeps every element in one bank, so consecutive elements issue exactly 4 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| store_i | input | 1 | 1 for store, 0 for load, sampled at start |
| base_i | input | ADDR_W | Word address of element 0 |
| stride_i | input | ADDR_W | Signed stride in words |
| vlen_i | input | VL_W | Requested vector length |
| busy_o | output | 1 | Transfer in progress |
| stall_o | output | 1 | Head element held by a busy bank |
| done_o | output | 1 | One-cycle completion pulse |
| rd_idx_o | output | IDX_W | Element index for store data read |
| rd_data_i | input | DATA_W | Store data for element rd_idx_o |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | ADDR_W | Word address of the access |
| mem_bank_o | output | BANK_W | Target bank |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, fixed latency after access |
| wb_valid_o | output | 1 | Load result valid |
| wb_idx_o | output | IDX_W | Element index of load result |
| wb_data_o | output | DATA_W | Load result data |

## Verification
The bench builds the engine with a 10-bit word address and the default 16 banks, 4-cycle bank recovery, 12-cycle return and 64-element maximum. It backs the engine with a 1024-word memory, which is small enough to model directly. With these values, strides 0 through 20, several negative strides and stride 48 can all be swept at full length. This drives every pattern of bank reuse, from no conflict through partial conflicts to a single-bank stream. The expected issue cycle of every element is derived from a per-bank free time, so the stall count, the return cycle and the completion cycle are all predicted exactly, including the effect of bank state left over from the previous transfer.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_DRAIN} eng_st_e;
endpackage

// File: rtl/vmem_addr_gen.sv
module vmem_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [IDX_W-1:0]  last_idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              last_o
);
  logic [ADDR_W-1:0] addr_q, stride_q;
  logic [IDX_W-1:0]  idx_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      stride_q <= '0;
      idx_q    <= '0;
      last_q   <= '0;
    end else if (load_i) begin
      addr_q   <= base_i;
      stride_q <= stride_i;
      idx_q    <= '0;
      last_q   <= last_idx_i;
    end else if (adv_i && (idx_q != last_q)) begin
      // running sum avoids a multiplier on the address path
      addr_q <= addr_q + stride_q;
      idx_q  <= idx_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign idx_o  = idx_q;
  assign last_o = (idx_q == last_q);
endmodule

// File: rtl/vmem_bank_track.sv
module vmem_bank_track #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int CNT_W    = $clog2(BUSY_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic              busy_o
);
  logic [NUM_BANKS-1:0] busy_vec;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cnt_q <= '0;
      else if (fire_i && (bank_i == BANK_W'(g)))    cnt_q <= CNT_W'(BUSY_CYC - 1);
      else if (cnt_q != '0)                         cnt_q <= cnt_q - 1'b1;
    end
    assign busy_vec[g] = (cnt_q != '0);
  end

  assign busy_o = busy_vec[bank_i];
endmodule

// File: rtl/vmem_ret_pipe.sv
module vmem_ret_pipe #(
  parameter int LAT   = 12,
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             last_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  logic [LAT-1:0] vld_q;
  logic [IDX_W:0] ent_q [LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int k = 0; k < LAT; k++) ent_q[k] <= '0;
    end else begin
      vld_q[0] <= push_i;
      ent_q[0] <= {last_i, idx_i};
      for (int k = 1; k < LAT; k++) begin
        vld_q[k] <= vld_q[k-1];
        ent_q[k] <= ent_q[k-1];
      end
    end
  end

  assign vld_o  = vld_q[LAT-1];
  assign idx_o  = ent_q[LAT-1][IDX_W-1:0];
  assign last_o = vld_q[LAT-1] & ent_q[LAT-1][IDX_W];
endmodule

// File: rtl/vmem_stride_engine.sv
module vmem_stride_engine #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 64,
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  parameter int LOAD_LAT  = 12,
  parameter int MAX_VL    = 64,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int VL_W     = $clog2(MAX_VL + 1),
  localparam int IDX_W    = $clog2(MAX_VL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              store_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [VL_W-1:0]   vlen_i,
  output logic              busy_o,
  output logic              stall_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BANK_W-1:0] mem_bank_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              wb_valid_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [DATA_W-1:0] wb_data_o
);
  import vmem_pkg::*;

  eng_st_e           st_q, st_d;
  logic              store_q, done_q;
  logic [VL_W-1:0]   vl_c;
  logic              start_ok, bank_busy, fire, last_el, ret_last;
  logic [ADDR_W-1:0] addr;
  logic [IDX_W-1:0]  idx;

  assign vl_c     = (vlen_i > VL_W'(MAX_VL)) ? VL_W'(MAX_VL) : vlen_i;
  assign start_ok = start_i && (st_q == ST_IDLE);
  assign fire     = (st_q == ST_ISSUE) && !bank_busy;

  vmem_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_agen (
    .clk_i, .rst_ni,
    .load_i     (start_ok),
    .adv_i      (fire),
    .base_i     (base_i),
    .stride_i   (stride_i),
    .last_idx_i (IDX_W'(vl_c - 1'b1)),
    .addr_o     (addr),
    .idx_o      (idx),
    .last_o     (last_el)
  );

  vmem_bank_track #(.NUM_BANKS(NUM_BANKS), .BUSY_CYC(BUSY_CYC)) u_bank (
    .clk_i, .rst_ni,
    .fire_i (fire),
    .bank_i (addr[BANK_W-1:0]),
    .busy_o (bank_busy)
  );

  vmem_ret_pipe #(.LAT(LOAD_LAT), .IDX_W(IDX_W)) u_ret (
    .clk_i, .rst_ni,
    .push_i (fire && !store_q),
    .idx_i  (idx),
    .last_i (last_el),
    .vld_o  (wb_valid_o),
    .idx_o  (wb_idx_o),
    .last_o (ret_last)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_ok && vl_c != '0) st_d = ST_ISSUE;
      ST_ISSUE: if (fire && last_el)        st_d = store_q ? ST_IDLE : ST_DRAIN;
      ST_DRAIN: if (ret_last)               st_d = ST_IDLE;
      default:                              st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      store_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (start_ok && vl_c == '0) || (fire && last_el && store_q) || ret_last;
      if (start_ok) store_q <= store_i;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign stall_o     = (st_q == ST_ISSUE) && bank_busy;
  assign done_o      = done_q;
  assign rd_idx_o    = idx;
  assign mem_req_o   = fire;
  assign mem_we_o    = fire && store_q;
  assign mem_addr_o  = addr;
  assign mem_bank_o  = addr[BANK_W-1:0];
  assign mem_wdata_o = rd_data_i;
  assign wb_data_o   = mem_rdata_i;
endmodule

// File: rtl/vmem_stride_engine_chk.sv
module vmem_stride_engine_chk #(
  parameter int NUM_BANKS = 16,
  parameter int BUSY_CYC  = 4,
  parameter int ADDR_W    = 16,
  parameter int IDX_W     = 6,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int AGE_W    = $clog2(BUSY_CYC + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              stall_o,
  input logic              done_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [BANK_W-1:0] mem_bank_o,
  input logic [IDX_W-1:0]  rd_idx_o,
  input logic              wb_valid_o,
  input logic [IDX_W-1:0]  wb_idx_o
);
  logic [AGE_W-1:0] age_q [NUM_BANKS];

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        age_q[g] <= AGE_W'(BUSY_CYC);
      else if (mem_req_o && mem_bank_o == BANK_W'(g))     age_q[g] <= AGE_W'(1);
      else if (age_q[g] < AGE_W'(BUSY_CYC))               age_q[g] <= age_q[g] + 1'b1;
    end
  end

  a_r3_bank_recovered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> age_q[mem_bank_o] >= AGE_W'(BUSY_CYC));

  a_r3_stall_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !mem_req_o);

  a_r3_stall_holds_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(mem_addr_o));

  a_r2_bank_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_bank_o == mem_addr_o[BANK_W-1:0]);

  a_r4_issue_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> (!mem_req_o || rd_idx_o == $past(rd_idx_o) + 1'b1));

  a_r4_req_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  a_r6_return_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> (!wb_valid_o || wb_idx_o == $past(wb_idx_o) + 1'b1));

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !mem_req_o));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind vmem_stride_engine vmem_stride_engine_chk #(
  .NUM_BANKS(NUM_BANKS), .BUSY_CYC(BUSY_CYC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .stall_o    (stall_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .mem_bank_o (mem_bank_o),
  .rd_idx_o   (rd_idx_o),
  .wb_valid_o (wb_valid_o),
  .wb_idx_o   (wb_idx_o)
);

// File: tb/vmem_stride_engine_tb_top.sv
module vmem_stride_engine_tb_top;
  localparam int AW = 10, DW = 64, NB = 16, BUSY = 4, LAT = 12, MVL = 64;
  localparam int VL_W = 7, IDX_W = 6, BW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, store = 1'b0;
  logic [AW-1:0] base = '0, stride = '0;
  logic [VL_W-1:0] vlen = '0;
  logic busy, stall, done, req, we, wb_valid;
  logic [IDX_W-1:0] rd_idx, wb_idx;
  logic [AW-1:0] addr;
  logic [BW-1:0] bank;
  logic [DW-1:0] rd_data, wdata, rdata, wb_data;

  int n_tests = 0, n_fail = 0, cyc = 0, op_id = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] init_val(input int a);
    return {32'hA5A5_0000 | 32'(a), 32'h5A5A_0000 ^ 32'(a)};
  endfunction
  function automatic logic [DW-1:0] st_pat(input int i, input int op);
    return {16'(op), 16'(i), 32'hC0DE_0000 | 32'(i)};
  endfunction

  assign rd_data = st_pat(int'(rd_idx), op_id);

  // memory model: writes at issue, read data presented LAT cycles later
  logic [DW-1:0] mem [2**AW];
  logic [DW-1:0] shadow [2**AW];
  logic [DW-1:0] rpipe [LAT];
  always @(posedge clk) begin
    if (req && we) mem[addr] <= wdata;
    rpipe[0] <= mem[addr];
    for (int k = 1; k < LAT; k++) rpipe[k] <= rpipe[k-1];
  end
  assign rdata = rpipe[LAT-1];

  vmem_stride_engine #(.ADDR_W(AW), .DATA_W(DW), .NUM_BANKS(NB), .BUSY_CYC(BUSY),
                       .LOAD_LAT(LAT), .MAX_VL(MVL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .store_i(store),
    .base_i(base), .stride_i(stride), .vlen_i(vlen),
    .busy_o(busy), .stall_o(stall), .done_o(done),
    .rd_idx_o(rd_idx), .rd_data_i(rd_data),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_bank_o(bank),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .wb_valid_o(wb_valid), .wb_idx_o(wb_idx), .wb_data_o(wb_data));

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  int exp_cyc [MVL];
  logic [AW-1:0] exp_addr [MVL];
  logic [DW-1:0] exp_dat [MVL];
  int bank_free [NB];
  int exp_n, exp_done, exp_stall;
  bit exp_store, mon_on = 1'b0, done_seen;
  int iss_cnt, wb_cnt, stall_cnt;

  always @(negedge clk) if (mon_on) begin
    if (req) begin
      if (iss_cnt < exp_n) begin
        chk(addr == exp_addr[iss_cnt], "R1", "address", 64'(addr), 64'(exp_addr[iss_cnt]));
        chk(bank == exp_addr[iss_cnt][BW-1:0], "R2", "bank", 64'(bank), 64'(exp_addr[iss_cnt][BW-1:0]));
        chk(cyc == exp_cyc[iss_cnt], "R3", "issue cycle", 64'(cyc), 64'(exp_cyc[iss_cnt]));
        chk(we == exp_store, "R7", "write enable", 64'(we), 64'(exp_store));
        if (exp_store)
          chk(wdata == exp_dat[iss_cnt], "R7", "store data", wdata, exp_dat[iss_cnt]);
      end else chk(1'b0, "R4", "extra access", 64'(iss_cnt), 64'(exp_n));
      iss_cnt++;
    end
    if (stall) stall_cnt++;
    if (wb_valid) begin
      if (!exp_store && wb_cnt < exp_n) begin
        chk(wb_idx == IDX_W'(wb_cnt), "R6", "return index", 64'(wb_idx), 64'(wb_cnt));
        chk(wb_data == exp_dat[wb_cnt], "R6", "return data", wb_data, exp_dat[wb_cnt]);
        chk(cyc == exp_cyc[wb_cnt] + LAT, "R6", "return cycle", 64'(cyc), 64'(exp_cyc[wb_cnt] + LAT));
      end else chk(1'b0, "R6", "unexpected return", 64'(wb_cnt), 64'(exp_n));
      wb_cnt++;
    end
    if (done) begin
      chk(cyc == exp_done, "R8", "done cycle", 64'(cyc), 64'(exp_done));
      chk(!busy, "R8", "busy at done", 64'(busy), 64'(0));
      done_seen = 1'b1;
    end
  end

  task automatic run_op(input bit st, input int b, input int s, input int vl, input bit poke);
    int n, s0, t, a, bk, guard;
    @(negedge clk);
    op_id++;
    n  = (vl > MVL) ? MVL : vl;
    s0 = cyc + 1;
    t  = s0 - 1;
    for (int i = 0; i < n; i++) begin
      a  = (b + i * s) & (2**AW - 1);
      bk = a % NB;
      t  = (t + 1 > bank_free[bk]) ? t + 1 : bank_free[bk];
      bank_free[bk] = t + BUSY;
      exp_cyc[i]  = t;
      exp_addr[i] = AW'(a);
      if (st) begin
        exp_dat[i] = st_pat(i, op_id);
        shadow[a]  = exp_dat[i];
      end else exp_dat[i] = shadow[a];
    end
    exp_n     = n;
    exp_store = st;
    exp_stall = (n == 0) ? 0 : t - s0 + 1 - n;
    exp_done  = (n == 0) ? s0 : (st ? t + 1 : t + LAT + 1);
    iss_cnt = 0; wb_cnt = 0; stall_cnt = 0; done_seen = 1'b0;
    start = 1'b1; store = st; base = AW'(b); stride = AW'(s); vlen = VL_W'(vl);
    @(negedge clk);
    start = 1'b0;
    if (n != 0) chk(busy, "R8", "busy after start", 64'(busy), 64'(1));
    if (poke) begin
      repeat (3) @(negedge clk);
      // R9: start while busy must be ignored
      start = 1'b1; store = ~st; base = AW'(b + 5); stride = AW'(1); vlen = VL_W'(3);
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done_seen && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    if (!done_seen) chk(1'b0, "R8", "watchdog, no done", 64'(guard), 64'(0));
    @(negedge clk);
    chk(iss_cnt == n, "R4", "access count", 64'(iss_cnt), 64'(n));
    chk(wb_cnt == (st ? 0 : n), "R6", "return count", 64'(wb_cnt), 64'(st ? 0 : n));
    chk(stall_cnt == exp_stall, "R3", "stall cycles", 64'(stall_cnt), 64'(exp_stall));
    chk(!busy, "R8", "idle after done", 64'(busy), 64'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int a = 0; a < 2**AW; a++) begin
      mem[a] = init_val(a);
      shadow[a] = init_val(a);
    end
    for (int k = 0; k < LAT; k++) rpipe[k] = '0;
    for (int k = 0; k < NB; k++) bank_free[k] = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({busy, stall, done, req, wb_valid} == 5'b0, "R10", "outputs in reset",
        64'({busy, stall, done, req, wb_valid}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, stall, done, req, wb_valid} == 5'b0, "R10", "outputs after reset",
        64'({busy, stall, done, req, wb_valid}), 64'(0));
    mon_on = 1'b1;
    run_op(1'b0, 40, 1, 0, 1'b0);              // R5 zero length
    for (int s = 0; s <= 20; s++) begin         // R1 R2 R3 sweep
      run_op(1'b0, s * 7, s, 64, 1'b0);
      run_op(1'b1, 100 + s * 3, s, 23, 1'b0);   // R7 stores
    end
    run_op(1'b0, 600, -1, 64, 1'b0);            // R1 negative stride
    run_op(1'b0, 900, -16, 40, 1'b1);           // R11 and R9 poke
    run_op(1'b0, 3, 48, 30, 1'b0);              // R11
    run_op(1'b1, 500, 3, 64, 1'b0);
    run_op(1'b0, 500, 3, 64, 1'b0);             // R6 reads back stored data
    run_op(1'b0, 17, 5, 100, 1'b0);             // R5 clamp to 64
    run_op(1'b1, 1020, 7, 127, 1'b1);           // R5 clamp, address wrap, R9
    run_op(1'b0, 1020, 7, 64, 1'b0);
    run_op(1'b0, 8, 2, 1, 1'b0);                // single element
    run_op(1'b1, 77, 16, 0, 1'b0);              // R5 zero-length store
    run_op(1'b0, 0, 16, 64, 1'b0);              // R11 full length single bank
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule